// File: doc/BRIEF.md
# SPI Flash Command Engine

This block is a register-programmed SPI host that performs one flash command each time software starts it. Software places an opcode in a dedicated register, sets how many payload bytes go out and how many response bytes come back, loads the outgoing payload into a 64-byte byte buffer, and then writes an execute code to a trigger register. The engine lowers chip-select and shifts out the opcode, then the payload. It then clocks in the response and writes it back into the same buffer, directly behind the payload. After a short chip-select high gap it reports idle again.

Software reaches every register and buffer location through a simple byte-wide write strobe and a combinational read port. The serial side runs in SPI mode 0, most significant bit first. The serial clock is derived from the system clock with a programmable half-period count. While a command runs, the configuration and the buffer are locked against software writes, and further triggers are discarded.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, chip-select is high, the serial clock is low, the status register (address 68) reads 0x00, and the divider register (address 69) reads 2.
- R2: A command shifts out the opcode register (address 64) first and then the payload bytes from buffer locations 0 upward, each byte MSB first. The number of payload bytes is the transmit-count register (address 65).
- R3: Response bytes are sampled MSB first and stored at buffer location (transmit count + j) for response byte j, where the count of response bytes is the receive-count register (address 66). The payload locations are left unchanged.
- R4: A trigger whose transmit count plus receive count exceeds 64 does not start. It leaves busy at 0 and chip-select high, and sets the error flag (status bit 1). An accepted trigger clears the error flag. A sum of exactly 64 is accepted.
- R5: Only writing 0xA5 to the trigger register (address 67) starts a command. Any other value written there has no effect.
- R6: The busy flag (status bit 0) is set from the clock edge that accepts the trigger for exactly 2·D·(8·B + 2) cycles. Here D is the effective divider and B = 1 + transmit count + receive count.
- R7: Chip-select is low for exactly 2·D·8·B cycles, starting at the accepting edge. It is then held high for 4·D cycles, which is two serial clock periods, before busy clears. Chip-select is never low while the engine is idle.
- R8: The serial clock idles low whenever chip-select is high. MOSI changes only while the serial clock is low, and MISO is sampled on the rising serial clock edge.
- R9: The serial clock is high for D cycles and low for D cycles per bit, so it is high for D·8·B cycles per command. D equals the divider register value, and a value of 0 acts as 1.
- R10: While busy, writes to the buffer, the opcode, both counts and the divider are ignored, and a second trigger neither restarts nor extends the running command.
- R11: With a receive count of 0, the command ends right after the last payload bit, with no response bytes clocked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Register write strobe, one cycle per write |
| busAddr | input | 8 | Register address: 0–63 buffer, 64 opcode, 65 transmit count, 66 receive count, 67 trigger, 68 status, 69 divider |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Combinational read data for busAddr |
| spiSclk | output | 1 | Serial clock, idle low |
| spiCsN | output | 1 | Active-low chip-select |
| spiMosi | output | 1 | Serial data to the flash |
| spiMiso | input | 1 | Serial data from the flash |

## Verification
Every timed result is counted from the clock edge that accepts the trigger write. The bench samples on falling clock edges starting with the first one after that edge. Busy is expected for 2·D·(8·B+2) of those samples, chip-select low for 2·D·8·B of them, and the serial clock high for D·8·B of them. A refused or ignored trigger is checked on the very next sample, through the status register and a count of chip-select falls. Buffer contents, the MOSI byte stream and the locked registers are read back only after busy has cleared. When writes are issued in the middle of a command, the samples they use are subtracted from the busy count.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int FIFO_DEPTH = 64;
  localparam int CNT_W      = 8;
  localparam int PTR_W      = $clog2(FIFO_DEPTH);

  localparam logic [7:0] EXEC_CODE = 8'hA5;

  // register offsets above the buffer window
  localparam int OFS_OPCODE = 0;
  localparam int OFS_TXCNT  = 1;
  localparam int OFS_RXCNT  = 2;
  localparam int OFS_TRIG   = 3;
  localparam int OFS_STAT   = 4;
  localparam int OFS_DIV    = 5;

  typedef struct packed {
    logic             start;
    logic             setErr;
    logic             loadOp;
    logic             loadFifo;
    logic             loadFill;
    logic             rise;
    logic             fall;
    logic             store;
    logic             csRelease;
    logic [PTR_W-1:0] rdPtr;
    logic [PTR_W-1:0] wrPtr;
  } engStb_t;
endpackage

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
  import spi_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             trigReq,
  input  logic [CNT_W-1:0] txCnt,
  input  logic [CNT_W-1:0] rxCnt,
  input  logic [CNT_W-1:0] halfDiv,
  output logic             busy,
  output engStb_t          stb
);
  localparam int SUM_W = CNT_W + 1;
  localparam int GAP_W = CNT_W + 2;

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH, S_GAP} state_t;

  state_t           state;
  logic [CNT_W-1:0] halfCnt;
  logic [2:0]       bitCnt;
  logic [SUM_W-1:0] byteIdx;
  logic [GAP_W-1:0] gapCnt;

  logic [SUM_W-1:0] xferSum;
  logic [SUM_W-1:0] nextIdx;
  logic [PTR_W-1:0] idxLow;
  logic             overLimit;
  logic             halfDone;
  logic             gapDone;
  logic             lastBit;
  logic             lastByte;
  logic             rxByte;

  assign xferSum   = {1'b0, txCnt} + {1'b0, rxCnt};
  assign overLimit = xferSum > SUM_W'(FIFO_DEPTH);
  assign nextIdx   = byteIdx + SUM_W'(1);
  assign idxLow    = byteIdx[PTR_W-1:0];
  assign halfDone  = halfCnt == (halfDiv - CNT_W'(1));
  assign gapDone   = gapCnt == ({halfDiv, 2'b00} - GAP_W'(1));
  assign lastBit   = bitCnt == 3'd7;
  assign lastByte  = byteIdx == xferSum;
  assign rxByte    = byteIdx > {1'b0, txCnt};
  assign busy      = state != S_IDLE;

  always_comb begin
    stb       = '0;
    stb.rdPtr = idxLow;
    stb.wrPtr = idxLow - PTR_W'(1);
    unique case (state)
      S_IDLE: begin
        if (trigReq) begin
          if (overLimit) stb.setErr = 1'b1;
          else begin
            stb.start  = 1'b1;
            stb.loadOp = 1'b1;
          end
        end
      end
      S_LOW: stb.rise = halfDone;
      S_HIGH: begin
        if (halfDone) begin
          stb.fall = 1'b1;
          if (lastBit) begin
            stb.store = rxByte;
            if (lastByte) stb.csRelease = 1'b1;
            else if (nextIdx <= {1'b0, txCnt}) stb.loadFifo = 1'b1;
            else stb.loadFill = 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      halfCnt <= '0;
      bitCnt  <= '0;
      byteIdx <= '0;
      gapCnt  <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (stb.start) begin
            state   <= S_LOW;
            halfCnt <= '0;
            bitCnt  <= '0;
            byteIdx <= '0;
          end
        end
        S_LOW: begin
          if (halfDone) begin
            halfCnt <= '0;
            state   <= S_HIGH;
          end else halfCnt <= halfCnt + CNT_W'(1);
        end
        S_HIGH: begin
          if (halfDone) begin
            halfCnt <= '0;
            bitCnt  <= bitCnt + 3'd1;
            if (lastBit && lastByte) begin
              state  <= S_GAP;
              gapCnt <= '0;
            end else begin
              state <= S_LOW;
              if (lastBit) byteIdx <= nextIdx;
            end
          end else halfCnt <= halfCnt + CNT_W'(1);
        end
        S_GAP: begin
          if (gapDone) state <= S_IDLE;
          else gapCnt <= gapCnt + GAP_W'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (xferSum <= SUM_W'(FIFO_DEPTH))); // R4
  AST_STORE_BEHIND_TX: assert property (@(posedge clk) disable iff (!rstN)
    stb.store |-> ({1'b0, stb.wrPtr} >= txCnt)); // R3
  AST_TRIG_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !stb.start); // R10
endmodule

// File: rtl/spi_cmd_dp.sv
module spi_cmd_dp
  import spi_cmd_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  input  logic              busy,
  input  engStb_t           stb,
  output logic              trigReq,
  output logic [CNT_W-1:0]  txCnt,
  output logic [CNT_W-1:0]  rxCnt,
  output logic [CNT_W-1:0]  halfDiv,
  output logic              spiSclk,
  output logic              spiCsN,
  output logic              spiMosi,
  input  logic              spiMiso
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(FIFO_DEPTH);

  logic [7:0]       fifoMem [FIFO_DEPTH];
  logic [7:0]       opReg;
  logic [CNT_W-1:0] divReg;
  logic             errFlag;
  logic [7:0]       shReg;
  logic [7:0]       shiftNext;
  logic             misoBit;
  logic             sclkR;
  logic             csNR;
  logic             isFifo;
  logic [ADDR_W-1:0] regSel;
  logic             cfgWr;

  assign isFifo    = busAddr < BASE;
  assign regSel    = busAddr - BASE;
  assign cfgWr     = busWr && !busy;
  assign trigReq   = busWr && !isFifo && (regSel == ADDR_W'(OFS_TRIG)) && (busWdata == EXEC_CODE);
  assign halfDiv   = (divReg == '0) ? CNT_W'(1) : divReg;
  assign shiftNext = {shReg[6:0], misoBit};
  assign spiSclk   = sclkR;
  assign spiCsN    = csNR;
  assign spiMosi   = shReg[7];

  always_ff @(posedge clk) begin
    if (stb.store) fifoMem[stb.wrPtr] <= shiftNext;
    else if (cfgWr && isFifo) fifoMem[busAddr[PTR_W-1:0]] <= busWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opReg  <= '0;
      txCnt  <= '0;
      rxCnt  <= '0;
      divReg <= CNT_W'(2);
    end else if (cfgWr && !isFifo) begin
      if (regSel == ADDR_W'(OFS_OPCODE)) opReg  <= busWdata;
      if (regSel == ADDR_W'(OFS_TXCNT))  txCnt  <= busWdata;
      if (regSel == ADDR_W'(OFS_RXCNT))  rxCnt  <= busWdata;
      if (regSel == ADDR_W'(OFS_DIV))    divReg <= busWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errFlag <= 1'b0;
      shReg   <= '0;
      misoBit <= 1'b0;
      sclkR   <= 1'b0;
      csNR    <= 1'b1;
    end else begin
      if (stb.setErr) errFlag <= 1'b1;
      else if (stb.start) errFlag <= 1'b0;
      if (stb.loadOp) shReg <= opReg;
      else if (stb.loadFifo) shReg <= fifoMem[stb.rdPtr];
      else if (stb.loadFill) shReg <= 8'hFF;
      else if (stb.fall) shReg <= shiftNext;
      if (stb.rise) begin
        sclkR   <= 1'b1;
        misoBit <= spiMiso;
      end else if (stb.fall) sclkR <= 1'b0;
      if (stb.start) csNR <= 1'b0;
      else if (stb.csRelease) csNR <= 1'b1;
    end
  end

  always_comb begin
    busRdata = 8'h00;
    if (isFifo) busRdata = fifoMem[busAddr[PTR_W-1:0]];
    else if (regSel == ADDR_W'(OFS_OPCODE)) busRdata = opReg;
    else if (regSel == ADDR_W'(OFS_TXCNT))  busRdata = txCnt;
    else if (regSel == ADDR_W'(OFS_RXCNT))  busRdata = rxCnt;
    else if (regSel == ADDR_W'(OFS_STAT))   busRdata = {6'b0, errFlag, busy};
    else if (regSel == ADDR_W'(OFS_DIV))    busRdata = divReg;
  end

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    csNR |-> !sclkR); // R8
  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (sclkR && $past(sclkR)) |-> $stable(spiMosi)); // R8
  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(txCnt) && $stable(rxCnt) && $stable(opReg) && $stable(divReg))); // R10
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  output logic              spiSclk,
  output logic              spiCsN,
  output logic              spiMosi,
  input  logic              spiMiso
);
  engStb_t          stb;
  logic             busy;
  logic             trigReq;
  logic [CNT_W-1:0] txCnt;
  logic [CNT_W-1:0] rxCnt;
  logic [CNT_W-1:0] halfDiv;

  spi_cmd_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .trigReq (trigReq),
    .txCnt   (txCnt),
    .rxCnt   (rxCnt),
    .halfDiv (halfDiv),
    .busy    (busy),
    .stb     (stb)
  );

  spi_cmd_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .busy     (busy),
    .stb      (stb),
    .trigReq  (trigReq),
    .txCnt    (txCnt),
    .rxCnt    (rxCnt),
    .halfDiv  (halfDiv),
    .spiSclk  (spiSclk),
    .spiCsN   (spiCsN),
    .spiMosi  (spiMosi),
    .spiMiso  (spiMiso)
  );

  AST_CS_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !spiCsN |-> busy); // R7
endmodule

// File: tb/sim_spi_cmd_engine.sv
module sim_spi_cmd_engine;
  localparam logic [7:0] A_OP = 8'd64, A_TX = 8'd65, A_RX = 8'd66,
                         A_TRIG = 8'd67, A_STAT = 8'd68, A_DIV = 8'd69;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWr = 1'b0;
  logic [7:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic spiSclk, spiCsN, spiMosi;
  logic spiMiso = 1'b0;

  int checks = 0;
  int failures = 0;
  int mBusy, mCs, mHi;
  int capBits = 0;
  int slvBit = 0;
  int csFalls = 0;
  logic [7:0] capBytes [80];

  always #4 clk = ~clk;

  spi_cmd_engine u0 (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .spiSclk(spiSclk), .spiCsN(spiCsN), .spiMosi(spiMosi),
    .spiMiso(spiMiso)
  );

  function automatic logic [7:0] respByte(int b);
    return 8'h5A ^ 8'(b * 29);
  endfunction

  function automatic logic respBit(int k);
    logic [7:0] v;
    v = respByte(k / 8);
    return v[7 - (k % 8)];
  endfunction

  // flash model: mode 0, drive on falling edge, capture MOSI on rising edge
  always @(negedge spiCsN) begin
    csFalls = csFalls + 1;
    slvBit = 0;
    capBits = 0;
    spiMiso = respBit(0);
  end
  always @(negedge spiSclk) if (!spiCsN) begin
    slvBit = slvBit + 1;
    spiMiso = respBit(slvBit);
  end
  always @(posedge spiSclk) if (!spiCsN) begin
    if (capBits < 640) capBytes[capBits / 8][7 - (capBits % 8)] = spiMosi;
    capBits = capBits + 1;
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic setup(input logic [7:0] op, input logic [7:0] tx, input logic [7:0] rx,
                       input logic [7:0] dv);
    busWrite(A_OP, op);
    busWrite(A_TX, tx);
    busWrite(A_RX, rx);
    busWrite(A_DIV, dv);
  endtask

  // samples from the current falling edge until busy drops
  task automatic measure();
    int guard = 0;
    mBusy = 0; mCs = 0; mHi = 0;
    busAddr = A_STAT;
    #1;
    while (busRdata[0] && guard < 60000) begin
      mBusy++;
      if (!spiCsN) mCs++;
      if (spiSclk) mHi++;
      guard++;
      @(negedge clk);
      #1;
    end
  endtask

  task automatic testReset();
    logic [7:0] v;
    check(spiCsN === 1'b1, "R1 csN", spiCsN, 1);
    check(spiSclk === 1'b0, "R1 sclk", spiSclk, 0);
    busRead(A_STAT, v); check(v == 8'h00, "R1 status", v, 0);
    busRead(A_DIV, v);  check(v == 8'h02, "R1 divider", v, 2);
  endtask

  task automatic testOpcodeOnly();
    setup(8'h06, 8'd0, 8'd0, 8'd1);
    busWrite(A_TRIG, 8'hA5);
    measure();
    check(mBusy == 20, "R6 busy cycles opcode-only", mBusy, 20);
    check(mCs == 16, "R7 cs low cycles opcode-only", mCs, 16);
    check(capBits == 8, "R11 bit count opcode-only", capBits, 8);
    check(capBytes[0] == 8'h06, "R2 opcode byte", capBytes[0], 8'h06);
  endtask

  task automatic testWrite();
    busWrite(8'd0, 8'h10); busWrite(8'd1, 8'h20); busWrite(8'd2, 8'h30);
    setup(8'h02, 8'd3, 8'd0, 8'd2);
    busWrite(A_TRIG, 8'hA5);
    measure();
    check(mBusy == 136, "R6 busy cycles tx3 div2", mBusy, 136);
    check(mCs == 128, "R7 cs low cycles tx3 div2", mCs, 128);
    check(capBits == 32, "R11 no rx clocks after payload", capBits, 32);
    check(capBytes[0] == 8'h02, "R2 opcode first", capBytes[0], 8'h02);
    check(capBytes[1] == 8'h10, "R2 payload 0", capBytes[1], 8'h10);
    check(capBytes[2] == 8'h20, "R2 payload 1", capBytes[2], 8'h20);
    check(capBytes[3] == 8'h30, "R2 payload 2", capBytes[3], 8'h30);
  endtask

  task automatic testRead();
    logic [7:0] v;
    busWrite(8'd0, 8'hA1); busWrite(8'd1, 8'hB2); busWrite(8'd2, 8'hC3);
    setup(8'h0B, 8'd3, 8'd4, 8'd1);
    busWrite(A_TRIG, 8'hA5);
    measure();
    check(mBusy == 132, "R6 busy cycles tx3 rx4", mBusy, 132);
    check(mCs == 128, "R7 cs low cycles tx3 rx4", mCs, 128);
    check(capBytes[3] == 8'hC3, "R2 last payload byte", capBytes[3], 8'hC3);
    for (int j = 0; j < 4; j++) begin
      busRead(8'(3 + j), v);
      check(v == respByte(4 + j), "R3 rx byte at tx offset", v, respByte(4 + j));
    end
    busRead(8'd0, v); check(v == 8'hA1, "R3 payload kept 0", v, 8'hA1);
    busRead(8'd2, v); check(v == 8'hC3, "R3 payload kept 2", v, 8'hC3);
  endtask

  task automatic testOverflow();
    logic [7:0] v;
    int falls;
    setup(8'h03, 8'd40, 8'd25, 8'd1);
    falls = csFalls;
    busWrite(A_TRIG, 8'hA5);
    busAddr = A_STAT;
    #1 check(busRdata == 8'h02, "R4 refused: err set, not busy", busRdata, 8'h02);
    repeat (4) @(negedge clk);
    check(csFalls == falls, "R4 refused: cs never low", csFalls, falls);
    // exactly 64 is accepted and clears the error
    setup(8'h03, 8'd0, 8'd64, 8'd1);
    busWrite(A_TRIG, 8'hA5);
    measure();
    check(mBusy == 1044, "R4 sum 64 accepted", mBusy, 1044);
    busRead(A_STAT, v); check(v == 8'h00, "R4 err cleared", v, 0);
    busRead(8'd0, v);  check(v == respByte(1), "R3 rx first at 0", v, respByte(1));
    busRead(8'd63, v); check(v == respByte(64), "R3 rx last at 63", v, respByte(64));
  endtask

  task automatic testBadCode();
    int falls;
    falls = csFalls;
    setup(8'h06, 8'd0, 8'd0, 8'd1);
    busWrite(A_TRIG, 8'h5A);
    busAddr = A_STAT;
    #1 check(busRdata == 8'h00, "R5 wrong code no start", busRdata, 0);
    repeat (4) @(negedge clk);
    check(csFalls == falls, "R5 wrong code cs idle", csFalls, falls);
  endtask

  task automatic testDivider();
    logic [7:0] v;
    busWrite(8'd0, 8'h44);
    setup(8'h9F, 8'd1, 8'd1, 8'd3);
    busWrite(A_TRIG, 8'hA5);
    measure();
    check(mHi == 72, "R9 sclk high cycles div3", mHi, 72);
    check(mBusy == 156, "R6 busy cycles div3", mBusy, 156);
    check(mCs == 144, "R7 cs low cycles div3", mCs, 144);
    busRead(8'd1, v); check(v == respByte(2), "R8 miso sampled div3", v, respByte(2));
    setup(8'h05, 8'd0, 8'd0, 8'd0);
    busWrite(A_TRIG, 8'hA5);
    measure();
    check(mHi == 8, "R9 divider 0 acts as 1 (high)", mHi, 8);
    check(mBusy == 20, "R9 divider 0 acts as 1 (busy)", mBusy, 20);
  endtask

  task automatic testLocked();
    logic [7:0] v;
    busWrite(8'd0, 8'h11); busWrite(8'd1, 8'h22);
    setup(8'h02, 8'd2, 8'd0, 8'd1);
    busWrite(A_TRIG, 8'hA5);
    busWrite(8'd0, 8'hEE);
    busWrite(A_TX, 8'd5);
    busWrite(A_TRIG, 8'hA5);
    measure();
    // six busy samples were taken up by the three writes
    check(mBusy == 46, "R10 busy not extended by retrigger", mBusy, 46);
    check(capBytes[1] == 8'h11, "R10 payload sent unchanged", capBytes[1], 8'h11);
    check(capBits == 24, "R10 bit count unchanged", capBits, 24);
    busRead(8'd0, v); check(v == 8'h11, "R10 buffer write ignored", v, 8'h11);
    busRead(A_TX, v); check(v == 8'd2, "R10 count write ignored", v, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testOpcodeOnly();
    testWrite();
    testRead();
    testOverflow();
    testBadCode();
    testDivider();
    testLocked();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule